// File: doc/BRIEF.md
# Threshold-Watch Conversion Controller

This controller sits between a free-running analog-to-digital converter and the interrupt logic of a processor. Software writes three small registers through a byte-wide write port. The first sets the run bit and the input channel. The second sets the compare options. The third holds the threshold. While the run bit is set, the block requests conversions and receives results on a valid/data pair. The conversion itself happens outside the block.

The first result that arrives after each start is not trustworthy, so the block discards it. In plain mode, every later result is loaded into the result register and raises the interrupt flag. In compare mode, results are still loaded. The interrupt is raised only when a result meets the threshold condition while the repeat bit is set. When that happens, the hardware clears the repeat bit in the same step. Conversions then continue without further interrupts until software sets the repeat bit again.

Top module: `pf_cmp_ctrl`

## Requirements
- R1: After reset, conv_req, irq and rep_on are 0, and result and chan_sel are all zeros.
- R2: A write to address 0 sets the run state to bit 7 of the written data, and conv_req follows it one clock later. Sample strobes that arrive while conv_req is 0 leave result and irq unchanged.
- R3: The first valid sample after each 0-to-1 change of the run state is dropped. It does not change result, does not raise irq and does not clear rep_on.
- R4: With the compare enable clear, every valid sample after the first loads result and sets irq on the next clock.
- R5: With the compare enable set (address 1, bit 7), irq is set only by a loaded sample that meets the condition while rep_on is 1. Bit 0 of address 1 picks the condition: 0 means sample >= threshold, and 1 means sample < threshold.
- R6: A sample that meets the condition in compare mode with rep_on set clears rep_on on the same clock edge that sets irq. A software write to address 1 in that same cycle takes precedence. Bit 5 of address 1 sets rep_on.
- R7: While rep_on is 0 in compare mode, samples still load result but never raise irq.
- R8: Once set, irq stays 1 until irq_clr is pulsed. It then falls on the next clock. If a clear and a new interrupt event occur in the same cycle, irq stays 1.
- R9: Bits 2:0 of an address-0 write load chan_sel only when the run state was 0 before that write and the value is 0 to 5. Other values, and writes made while running, leave chan_sel unchanged.
- R10: A write to address 2 sets the threshold used by the R5 comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 compare, 2 threshold |
| wr_data | input | DW | Register write data |
| irq_clr | input | 1 | Pulse that clears the interrupt flag |
| smp_valid | input | 1 | Converter result strobe |
| smp_data | input | DW | Converter result value |
| conv_req | output | 1 | Conversion request to the converter (run state) |
| chan_sel | output | CW | Selected input channel |
| result | output | DW | Last accepted conversion result |
| irq | output | 1 | Sticky interrupt request |
| rep_on | output | 1 | Repeat-mode bit as currently held |

## Verification
Every output is a register. A write, a sample strobe or a clear shows up on conv_req, chan_sel, rep_on, result or irq exactly one rising edge after the cycle in which it was presented. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It compares the outputs at that second falling edge, which is half a period after the edge that captured the stimulus, so no check races the clock. The threshold sweep repeats this single-edge pattern for every 8-bit sample value against each boundary threshold, in both compare directions.

// File: rtl/pf_cmp_pkg.sv
package pf_cmp_pkg;
  // register addresses
  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_CMP  = 2'd1;
  localparam logic [1:0] A_THR  = 2'd2;
  // bit positions inside the mode and compare registers
  localparam int B_RUN  = 7;
  localparam int B_PFEN = 7;
  localparam int B_REP  = 5;
  localparam int B_DIR  = 0;
endpackage

// File: rtl/pf_regs.sv
module pf_regs
  import pf_cmp_pkg::*;
#(
  parameter int DW  = 8,
  parameter int NCH = 6,
  parameter int CW  = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rep_clr,
  output logic          run,
  output logic [CW-1:0] chan,
  output logic          pf_en,
  output logic          rep,
  output logic          dir,
  output logic [DW-1:0] thr,
  output logic          start_evt
);
  logic wr_mode, wr_cmp, wr_thr;

  function automatic logic chan_ok(input logic [CW-1:0] c);
    return int'(c) < NCH;
  endfunction

  assign wr_mode   = wr_en && (wr_addr == A_MODE);
  assign wr_cmp    = wr_en && (wr_addr == A_CMP);
  assign wr_thr    = wr_en && (wr_addr == A_THR);
  assign start_evt = wr_mode && wr_data[B_RUN] && !run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      chan  <= '0;
      pf_en <= 1'b0;
      rep   <= 1'b0;
      dir   <= 1'b0;
      thr   <= '0;
    end else begin
      if (wr_mode) begin
        run <= wr_data[B_RUN];
        if (!run && chan_ok(wr_data[CW-1:0])) chan <= wr_data[CW-1:0];
      end
      if (wr_cmp) begin
        pf_en <= wr_data[B_PFEN];
        rep   <= wr_data[B_REP];
        dir   <= wr_data[B_DIR];
      end else if (rep_clr) begin
        rep <= 1'b0;
      end
      if (wr_thr) thr <= wr_data;
    end
  end
endmodule

// File: rtl/pf_datapath.sv
module pf_datapath #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          start_evt,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic [DW-1:0] thr,
  input  logic          dir,
  output logic [DW-1:0] result,
  output logic          res_load,
  output logic          first_drop,
  output logic          hit
);
  logic first_q;
  logic take;

  function automatic logic meets(input logic [DW-1:0] v, input logic [DW-1:0] t,
                                 input logic below);
    return below ? (v < t) : (v >= t);
  endfunction

  assign take       = smp_valid && run;
  assign first_drop = take && first_q;
  assign res_load   = take && !first_q;
  assign hit        = meets(smp_data, thr, dir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      result  <= '0;
    end else begin
      if (start_evt)  first_q <= 1'b1;
      else if (take)  first_q <= 1'b0;
      if (res_load)   result  <= smp_data;
    end
  end
endmodule

// File: rtl/pf_irq.sv
module pf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic res_load,
  input  logic hit,
  input  logic pf_en,
  input  logic rep,
  input  logic irq_clr,
  output logic irq,
  output logic irq_evt,
  output logic rep_clr
);
  logic match_evt;

  assign match_evt = res_load && pf_en && hit && rep;
  assign irq_evt   = (res_load && !pf_en) || match_evt;
  assign rep_clr   = match_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (irq_evt) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end
endmodule

// File: rtl/pf_cmp_ctrl.sv
module pf_cmp_ctrl #(
  parameter int DW  = 8,
  parameter int NCH = 6,
  parameter int CW  = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          irq_clr,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  output logic          conv_req,
  output logic [CW-1:0] chan_sel,
  output logic [DW-1:0] result,
  output logic          irq,
  output logic          rep_on
);
  logic          run, pf_en, dir, start_evt;
  logic [DW-1:0] thr;
  logic          res_load, first_drop, hit;
  logic          irq_evt, rep_clr;

  pf_regs #(.DW(DW), .NCH(NCH), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rep_clr(rep_clr), .run(run), .chan(chan_sel), .pf_en(pf_en), .rep(rep_on),
    .dir(dir), .thr(thr), .start_evt(start_evt)
  );

  pf_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .run(run), .start_evt(start_evt),
    .smp_valid(smp_valid), .smp_data(smp_data), .thr(thr), .dir(dir),
    .result(result), .res_load(res_load), .first_drop(first_drop), .hit(hit)
  );

  pf_irq u_irq (
    .clk(clk), .rst_n(rst_n), .res_load(res_load), .hit(hit), .pf_en(pf_en),
    .rep(rep_on), .irq_clr(irq_clr), .irq(irq), .irq_evt(irq_evt), .rep_clr(rep_clr)
  );

  assign conv_req = run;
endmodule

// File: rtl/pf_cmp_ctrl_chk.sv
module pf_cmp_ctrl_chk #(
  parameter int NCH = 6,
  parameter int CW  = $clog2(NCH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic          irq_clr,
  input logic          conv_req,
  input logic [CW-1:0] chan_sel,
  input logic          irq,
  input logic          rep_on,
  input logic          irq_evt,
  input logic          hit,
  input logic          pf_en,
  input logic          first_drop
);
  // R2: no interrupt event while stopped
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_req |-> !irq_evt);
  // R3: dropped first sample never produces an event
  a_r3_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
    first_drop |-> !irq_evt);
  // R5: compare-mode events need a hit with repeat armed
  a_r5_match_only: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt && pf_en) |-> (hit && rep_on));
  // R6: repeat bit drops after a compare-mode event
  a_r6_rep_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt && pf_en && !(wr_en && wr_addr == 2'd1)) |=> !rep_on);
  // R8: flag is sticky and set wins over clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt |=> irq);
  // R9: channel frozen while running, always in range
  a_r9_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> $stable(chan_sel));
  a_r9_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(chan_sel) < NCH);
endmodule

bind pf_cmp_ctrl pf_cmp_ctrl_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .irq_clr(irq_clr),
  .conv_req(conv_req), .chan_sel(chan_sel), .irq(irq), .rep_on(rep_on),
  .irq_evt(irq_evt), .hit(hit), .pf_en(pf_en), .first_drop(first_drop)
);

// File: tb/pf_cmp_ctrl_tb.sv
module pf_cmp_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       irq_clr = 1'b0;
  logic       smp_valid = 1'b0;
  logic [7:0] smp_data = '0;
  logic       conv_req, irq, rep_on;
  logic [2:0] chan_sel;
  logic [7:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] last_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  pf_cmp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_clr(irq_clr), .smp_valid(smp_valid), .smp_data(smp_data),
    .conv_req(conv_req), .chan_sel(chan_sel), .result(result), .irq(irq), .rep_on(rep_on)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic clr);
    wr_en = 1'b1; wr_addr = a; wr_data = d; irq_clr = clr;
    @(negedge clk);
    wr_en = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic smp(input logic [7:0] d, input logic clr);
    smp_valid = 1'b1; smp_data = d; irq_clr = clr;
    @(negedge clk);
    smp_valid = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic clr_irq();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  function automatic bit want_hit(input int d, input int t, input int below);
    if (below != 0) return (t - d) > 0;
    return (d - t) >= 0;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 conv_req", conv_req, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rep_on", rep_on, 0);
    chk("R1 result", result, 0);
    chk("R1 chan_sel", chan_sel, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: stopped sample ignored
    smp(8'h55, 1'b0);
    chk("R2 stopped result", result, 0);
    chk("R2 stopped irq", irq, 0);

    // R10 threshold, plain mode, start on channel 2
    wr(2'd2, 8'h80, 1'b0);
    wr(2'd1, 8'h00, 1'b0);
    wr(2'd0, 8'h82, 1'b0);
    chk("R2 start", conv_req, 1);
    chk("R9 chan at start", chan_sel, 2);

    // R3: first result dropped
    smp(8'hAA, 1'b0);
    chk("R3 first result", result, 0);
    chk("R3 first irq", irq, 0);

    // R4: plain mode interrupts on each sample
    smp(8'h11, 1'b0);
    chk("R4 result", result, 8'h11);
    chk("R4 irq", irq, 1);
    clr_irq();
    chk("R8 cleared", irq, 0);
    smp(8'h22, 1'b0);
    chk("R4 second irq", irq, 1);
    chk("R4 second result", result, 8'h22);
    repeat (2) @(negedge clk);
    chk("R8 sticky", irq, 1);

    // R8: clear and new event together keep irq set
    smp(8'h33, 1'b1);
    chk("R8 set over clear", irq, 1);
    chk("R4 third result", result, 8'h33);
    clr_irq();
    chk("R8 clear", irq, 0);

    // R9: channel rules
    wr(2'd0, 8'h84, 1'b0);
    chk("R9 running write", chan_sel, 2);
    wr(2'd0, 8'h04, 1'b0);
    chk("R2 stop", conv_req, 0);
    chk("R9 write at stop", chan_sel, 2);
    wr(2'd0, 8'h06, 1'b0);
    chk("R9 value 6 ignored", chan_sel, 2);
    wr(2'd0, 8'h05, 1'b0);
    chk("R9 value 5 taken", chan_sel, 5);
    smp(8'h44, 1'b0);
    chk("R2 stopped again", result, 8'h33);
    chk("R2 stopped again irq", irq, 0);
    last_res = 8'h33;

    // Sweep: R5 R6 R7 R10 over both directions and boundary thresholds
    for (int dr = 0; dr < 2; dr++) begin
      for (int ti = 0; ti < 6; ti++) begin
        int t;
        case (ti)
          0: t = 0;    1: t = 1;    2: t = 127;
          3: t = 128;  4: t = 254;  default: t = 255;
        endcase
        wr(2'd0, 8'h00, 1'b0);
        wr(2'd2, 8'(t), 1'b0);
        wr(2'd1, 8'(8'hA0 | dr), 1'b1);
        wr(2'd0, 8'h80, 1'b0);
        smp((dr != 0) ? 8'h00 : 8'hFF, 1'b0);
        chk("R3 sweep first irq", irq, 0);
        chk("R3 sweep first rep_on", rep_on, 1);
        chk("R3 sweep first result", result, last_res);
        for (int d = 0; d < 256; d++) begin
          bit e;
          e = want_hit(d, t, dr);
          wr(2'd1, 8'(8'hA0 | dr), 1'b1);
          smp(8'(d), 1'b0);
          chk("R5 irq vs condition", irq, e);
          chk("R6 rep_on after sample", rep_on, !e);
          chk("R7 result loads", result, d);
          last_res = 8'(d);
          if (e && (d % 32 == 0)) begin
            clr_irq();
            smp(8'(d), 1'b0);
            chk("R7 no irq after clear of repeat", irq, 0);
            chk("R7 repeat stays off", rep_on, 0);
          end
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule